// File: doc/BRIEF.md
# Tagged Guest Translation Cache

This block is a small fully associative cache of finished guest-virtual to physical page translations. Every entry carries, besides its virtual page number, the identifier of the virtual machine and the identifier of the guest process that own it. Translations of many machines and processes therefore sit side by side. Switching the active machine or process needs no flush, because a lookup only hits on an entry whose owner tags equal the ones presented with the request.

A walker or a higher-level controller places completed translations through the fill port. Software-driven maintenance reaches the block as an invalidate command that clears everything, one machine, or one process of one machine. The lookup port returns hit, physical page and a permission field one clock after the request. A mode input selects whether the machine identifier is compared over all 16 bits or over its low 8 bits only.

Top module: `tagCache`

## Requirements
- R1: After reset every entry is invalid: any lookup misses, and `rspValid` and `rspHit` are low while no lookup is in flight.
- R2: A lookup presented with `lkValid` high in one cycle gives `rspValid` high in the next cycle, together with `rspHit`, `rspPpn` and `rspPerm`. `rspValid` is low in every other cycle, and `rspHit` is never high while `rspValid` is low.
- R3: A lookup hits only when a valid entry matches the virtual page number, the machine identifier and the process identifier. A difference in any one of the three gives a miss.
- R4: With `wideVmid` low, only bits 7:0 of every machine identifier (lookup, fill and invalidate) are compared, and bits 15:8 are treated as zero. With `wideVmid` high, all 16 bits are compared.
- R5: Presenting a different machine or process identifier on a lookup removes nothing. A later lookup with the original identifiers still hits.
- R6: An invalidate with `invKind` = 2'b00 clears every entry.
- R7: An invalidate with `invKind` = 2'b01 clears every entry whose machine identifier matches `invVmid`, whatever its process identifier, and leaves all other entries. It takes effect in one clock cycle.
- R8: An invalidate with `invKind` = 2'b10 clears only entries whose machine identifier matches `invVmid` and whose process identifier matches `invAsid`.
- R9: An invalidate with `invKind` = 2'b11 has no effect on any entry.
- R10: A fill in the same cycle as an invalidate is applied after it. The filled translation survives even when it matches the invalidated tags.
- R11: A fill whose page number, machine and process all match a valid entry overwrites that entry, so a later lookup returns the new page and permissions and no duplicate remains.
- R12: The cache holds 16 entries. A new fill takes the lowest-numbered free entry. When none is free, it takes the entry pointed to by a round-robin pointer, which is zero after reset and advances by one, wrapping, on each such eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wideVmid | input | 1 | 1: full 16-bit machine identifier compared; 0: low 8 bits only |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | 20 | Lookup virtual page number |
| lkVmid | input | 16 | Active machine identifier |
| lkAsid | input | 16 | Active process identifier |
| rspValid | output | 1 | Lookup result valid, one cycle after the request |
| rspHit | output | 1 | Lookup hit |
| rspPpn | output | 24 | Physical page on hit, zero on miss |
| rspPerm | output | 3 | Permission field on hit, zero on miss |
| fillValid | input | 1 | Write a translation |
| fillVpn | input | 20 | Fill virtual page number |
| fillVmid | input | 16 | Fill machine identifier |
| fillAsid | input | 16 | Fill process identifier |
| fillPpn | input | 24 | Fill physical page |
| fillPerm | input | 3 | Fill permission field |
| invValid | input | 1 | Invalidate command |
| invKind | input | 2 | 00 all, 01 by machine, 10 by machine and process, 11 none |
| invVmid | input | 16 | Invalidate machine identifier |
| invAsid | input | 16 | Invalidate process identifier |

## Verification
A corrupted valid bit or tag shows up at the lookup port on the next lookup of that translation, one cycle after the request. It appears either as a hit where an invalidate should have removed the entry or as a miss for a translation that was filled. A wrong victim choice or pointer stays hidden until the cache is full. It then shows as the wrong translation missing after the seventeenth and eighteenth fills. The checks therefore fill, invalidate and probe every tag combination on both sides of each command.

// File: rtl/tagCachePkg.sv
package tagCachePkg;
  localparam int VMID_W   = 16;
  localparam int NARROW_W = 8;
  localparam int ASID_W   = 16;

  typedef enum logic [1:0] {
    INV_ALL   = 2'b00,
    INV_VM    = 2'b01,
    INV_VM_AS = 2'b10,
    INV_NONE  = 2'b11
  } invKind_t;

  typedef struct packed {
    logic wrEn;
    logic invEn;
  } cacheStrb_t;

  function automatic logic [VMID_W-1:0] effVmid(input logic [VMID_W-1:0] v, input logic wide);
    return wide ? v : {{(VMID_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
  endfunction
endpackage

// File: rtl/tagCacheCtrl.sv
module tagCacheCtrl
  import tagCachePkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               invValid,
  input  logic [1:0]         invKind,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] vmMatchVec,
  input  logic [ENTRIES-1:0] asMatchVec,
  input  logic [ENTRIES-1:0] fillTagVec,
  output cacheStrb_t         strb,
  output logic [ENTRIES-1:0] clrMask,
  output logic [ENTRIES-1:0] wrSel
);
  logic [IDX_W-1:0]   rrPtr;
  logic [IDX_W-1:0]   selIdx;
  logic [ENTRIES-1:0] freeVec;
  logic [ENTRIES-1:0] dupVec;
  logic               evict;
  invKind_t           kind;

  function automatic logic [IDX_W-1:0] firstSet(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign kind = invKind_t'(invKind);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      unique case (kind)
        INV_ALL:   clrMask[i] = invValid;
        INV_VM:    clrMask[i] = invValid && vmMatchVec[i];
        INV_VM_AS: clrMask[i] = invValid && vmMatchVec[i] && asMatchVec[i];
        default:   clrMask[i] = 1'b0;
      endcase
    end
  end

  assign freeVec = ~validVec | clrMask;
  assign dupVec  = fillTagVec & validVec & ~clrMask;

  always_comb begin
    evict = 1'b0;
    if (|dupVec)       selIdx = firstSet(dupVec);
    else if (|freeVec) selIdx = firstSet(freeVec);
    else begin
      selIdx = rrPtr;
      evict  = 1'b1;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      wrSel[i] = fillValid && (selIdx == IDX_W'(i));
    end
  end

  assign strb.wrEn  = fillValid;
  assign strb.invEn = invValid && (kind != INV_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (fillValid && evict) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  AST_INV_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    invValid && kind == INV_ALL && !fillValid |=> validVec == '0); // R6
  AST_INV_VM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    invValid && kind == INV_VM && !fillValid |=> (validVec & $past(vmMatchVec)) == '0); // R7
  AST_INV_NONE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    invValid && kind == INV_NONE && !fillValid |=> validVec == $past(validVec)); // R9
  AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> $onehot(wrSel)); // R12
endmodule

// File: rtl/tagCacheData.sv
module tagCacheData
  import tagCachePkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 24,
  parameter int PERM_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wideVmid,
  input  logic               lkValid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [VMID_W-1:0]  lkVmid,
  input  logic [ASID_W-1:0]  lkAsid,
  output logic               rspValid,
  output logic               rspHit,
  output logic [PPN_W-1:0]   rspPpn,
  output logic [PERM_W-1:0]  rspPerm,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [VMID_W-1:0]  fillVmid,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic [PERM_W-1:0]  fillPerm,
  input  logic [VMID_W-1:0]  invVmid,
  input  logic [ASID_W-1:0]  invAsid,
  input  cacheStrb_t         strb,
  input  logic [ENTRIES-1:0] clrMask,
  input  logic [ENTRIES-1:0] wrSel,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] vmMatchVec,
  output logic [ENTRIES-1:0] asMatchVec,
  output logic [ENTRIES-1:0] fillTagVec
);
  logic [VPN_W-1:0]   eVpn  [ENTRIES];
  logic [VMID_W-1:0]  eVmid [ENTRIES];
  logic [ASID_W-1:0]  eAsid [ENTRIES];
  logic [PPN_W-1:0]   ePpn  [ENTRIES];
  logic [PERM_W-1:0]  ePerm [ENTRIES];
  logic [ENTRIES-1:0] hitVec;
  logic [PPN_W-1:0]   ppnSel;
  logic [PERM_W-1:0]  permSel;

  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    logic [VMID_W-1:0] storedEff;
    assign storedEff = effVmid(eVmid[g], wideVmid);
    assign hitVec[g] = validVec[g] && eVpn[g] == lkVpn
                       && storedEff == effVmid(lkVmid, wideVmid) && eAsid[g] == lkAsid;
    assign vmMatchVec[g] = storedEff == effVmid(invVmid, wideVmid);
    assign asMatchVec[g] = eAsid[g] == invAsid;
    assign fillTagVec[g] = eVpn[g] == fillVpn
                           && storedEff == effVmid(fillVmid, wideVmid) && eAsid[g] == fillAsid;
  end

  always_comb begin
    ppnSel  = '0;
    permSel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        ppnSel  = ppnSel | ePpn[i];
        permSel = permSel | ePerm[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
    end else begin
      validVec <= (validVec & ~(clrMask & {ENTRIES{strb.invEn}}))
                  | (wrSel & {ENTRIES{strb.wrEn}});
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strb.wrEn && wrSel[i]) begin
        eVpn[i]  <= fillVpn;
        eVmid[i] <= fillVmid;
        eAsid[i] <= fillAsid;
        ePpn[i]  <= fillPpn;
        ePerm[i] <= fillPerm;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspPpn   <= '0;
      rspPerm  <= '0;
    end else begin
      rspValid <= lkValid;
      rspHit   <= lkValid && (|hitVec);
      rspPpn   <= lkValid ? ppnSel : '0;
      rspPerm  <= lkValid ? permSel : '0;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid); // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid); // R2
  AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspHit); // R2
  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec)); // R11
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (validVec & $past(wrSel)) == $past(wrSel)); // R10
endmodule

// File: rtl/tagCache.sv
module tagCache
  import tagCachePkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 24,
  parameter int PERM_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wideVmid,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [15:0]       lkVmid,
  input  logic [15:0]       lkAsid,
  output logic              rspValid,
  output logic              rspHit,
  output logic [PPN_W-1:0]  rspPpn,
  output logic [PERM_W-1:0] rspPerm,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [15:0]       fillVmid,
  input  logic [15:0]       fillAsid,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [PERM_W-1:0] fillPerm,
  input  logic              invValid,
  input  logic [1:0]        invKind,
  input  logic [15:0]       invVmid,
  input  logic [15:0]       invAsid
);
  cacheStrb_t         strb;
  logic [ENTRIES-1:0] clrMask;
  logic [ENTRIES-1:0] wrSel;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] vmMatchVec;
  logic [ENTRIES-1:0] asMatchVec;
  logic [ENTRIES-1:0] fillTagVec;

  tagCacheCtrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .invValid(invValid),
    .invKind(invKind), .validVec(validVec), .vmMatchVec(vmMatchVec),
    .asMatchVec(asMatchVec), .fillTagVec(fillTagVec), .strb(strb),
    .clrMask(clrMask), .wrSel(wrSel)
  );

  tagCacheData #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)) u_data (
    .clk(clk), .rstN(rstN), .wideVmid(wideVmid), .lkValid(lkValid),
    .lkVpn(lkVpn), .lkVmid(lkVmid), .lkAsid(lkAsid), .rspValid(rspValid),
    .rspHit(rspHit), .rspPpn(rspPpn), .rspPerm(rspPerm), .fillVpn(fillVpn),
    .fillVmid(fillVmid), .fillAsid(fillAsid), .fillPpn(fillPpn),
    .fillPerm(fillPerm), .invVmid(invVmid), .invAsid(invAsid), .strb(strb),
    .clrMask(clrMask), .wrSel(wrSel), .validVec(validVec),
    .vmMatchVec(vmMatchVec), .asMatchVec(asMatchVec), .fillTagVec(fillTagVec)
  );
endmodule

// File: tb/tagCache_bench.sv
module tagCache_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wideVmid = 1'b1;
  logic        lkValid = 1'b0;
  logic [19:0] lkVpn = '0;
  logic [15:0] lkVmid = '0, lkAsid = '0;
  logic        rspValid, rspHit;
  logic [23:0] rspPpn;
  logic [2:0]  rspPerm;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [15:0] fillVmid = '0, fillAsid = '0;
  logic [23:0] fillPpn = '0;
  logic [2:0]  fillPerm = '0;
  logic        invValid = 1'b0;
  logic [1:0]  invKind = 2'b11;
  logic [15:0] invVmid = '0, invAsid = '0;
  int nChecks = 0, nFails = 0;
  logic gotHit;
  logic [23:0] gotPpn;
  logic [2:0]  gotPerm;

  always #5 clk = ~clk;

  tagCache u_tagCache (.*);

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic doLookup(input logic [19:0] vpn, input logic [15:0] vm, input logic [15:0] as);
    @(negedge clk);
    lkValid = 1'b1; lkVpn = vpn; lkVmid = vm; lkAsid = as;
    @(negedge clk);
    lkValid = 1'b0;
    check(rspValid === 1'b1, "R2 rspValid", rspValid, 1);
    gotHit = rspHit; gotPpn = rspPpn; gotPerm = rspPerm;
  endtask

  task automatic expectHit(input string req, input logic [19:0] vpn, input logic [15:0] vm,
                           input logic [15:0] as, input logic [23:0] ppn, input logic [2:0] perm);
    doLookup(vpn, vm, as);
    check(gotHit === 1'b1, req, gotHit, 1);
    check(gotPpn === ppn && gotPerm === perm, req, {gotPpn, gotPerm}, {ppn, perm});
  endtask

  task automatic expectMiss(input string req, input logic [19:0] vpn, input logic [15:0] vm,
                            input logic [15:0] as);
    doLookup(vpn, vm, as);
    check(gotHit === 1'b0, req, gotHit, 0);
  endtask

  task automatic setFill(input logic [19:0] vpn, input logic [15:0] vm, input logic [15:0] as,
                         input logic [23:0] ppn, input logic [2:0] perm);
    fillValid = 1'b1; fillVpn = vpn; fillVmid = vm; fillAsid = as; fillPpn = ppn; fillPerm = perm;
  endtask

  task automatic doFill(input logic [19:0] vpn, input logic [15:0] vm, input logic [15:0] as,
                        input logic [23:0] ppn, input logic [2:0] perm);
    @(negedge clk);
    setFill(vpn, vm, as, ppn, perm);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doInv(input logic [1:0] kind, input logic [15:0] vm, input logic [15:0] as);
    @(negedge clk);
    invValid = 1'b1; invKind = kind; invVmid = vm; invAsid = as;
    @(negedge clk);
    invValid = 1'b0;
  endtask

  task automatic testReset();
    check(rspValid === 1'b0 && rspHit === 1'b0, "R1 idle outputs", {rspValid, rspHit}, 0);
    expectMiss("R1 empty after reset", 20'h0, 16'h0, 16'h0);
    @(negedge clk);
    check(rspValid === 1'b0, "R2 no lookup no response", rspValid, 0);
  endtask

  task automatic testReplacement();
    for (int i = 0; i < 16; i++) doFill(20'h100 + 20'(i), 16'h1, 16'h1, 24'h1000 + 24'(i), 3'd1);
    doFill(20'h105, 16'h1, 16'h1, 24'hABC, 3'd2);
    expectHit("R11 overwrite same tag", 20'h105, 16'h1, 16'h1, 24'hABC, 3'd2);
    expectHit("R12 no eviction by overwrite", 20'h100, 16'h1, 16'h1, 24'h1000, 3'd1);
    doFill(20'h200, 16'h1, 16'h1, 24'h2000, 3'd3);
    doFill(20'h201, 16'h1, 16'h1, 24'h2001, 3'd3);
    expectMiss("R12 first victim entry0", 20'h100, 16'h1, 16'h1);
    expectMiss("R12 second victim entry1", 20'h101, 16'h1, 16'h1);
    expectHit("R12 entry2 kept", 20'h102, 16'h1, 16'h1, 24'h1002, 3'd1);
    expectHit("R12 new fill present", 20'h201, 16'h1, 16'h1, 24'h2001, 3'd3);
    doInv(2'b00, 16'h0, 16'h0);
    expectMiss("R6 invalidate all", 20'h102, 16'h1, 16'h1);
    expectMiss("R6 invalidate all b", 20'h200, 16'h1, 16'h1);
  endtask

  task automatic testTags();
    doFill(20'h300, 16'h0007, 16'h0011, 24'h3000, 3'd5);
    expectHit("R3 exact match", 20'h300, 16'h0007, 16'h0011, 24'h3000, 3'd5);
    expectMiss("R3 vpn differs", 20'h301, 16'h0007, 16'h0011);
    expectMiss("R3 vmid differs R5", 20'h300, 16'h0008, 16'h0011);
    expectMiss("R3 asid differs R5", 20'h300, 16'h0007, 16'h0012);
    expectHit("R5 entry kept after switch", 20'h300, 16'h0007, 16'h0011, 24'h3000, 3'd5);
  endtask

  task automatic testNarrow();
    doInv(2'b00, 16'h0, 16'h0);
    wideVmid = 1'b0;
    doFill(20'h400, 16'h1234, 16'h0002, 24'h4000, 3'd6);
    expectHit("R4 narrow ignores upper", 20'h400, 16'hAB34, 16'h0002, 24'h4000, 3'd6);
    expectMiss("R4 narrow low byte differs", 20'h400, 16'h1235, 16'h0002);
    wideVmid = 1'b1;
    expectMiss("R4 wide compares upper", 20'h400, 16'hAB34, 16'h0002);
    expectHit("R4 wide exact", 20'h400, 16'h1234, 16'h0002, 24'h4000, 3'd6);
    wideVmid = 1'b0;
    doInv(2'b01, 16'hFF34, 16'h0);
    expectMiss("R4 narrow invalidate match", 20'h400, 16'h1234, 16'h0002);
    wideVmid = 1'b1;
  endtask

  task automatic testInvSelective();
    doInv(2'b00, 16'h0, 16'h0);
    doFill(20'h500, 16'h0005, 16'h0001, 24'h5001, 3'd1);
    doFill(20'h500, 16'h0005, 16'h0002, 24'h5002, 3'd2);
    doFill(20'h500, 16'h0006, 16'h0001, 24'h6001, 3'd3);
    doInv(2'b11, 16'h0005, 16'h0001);
    expectHit("R9 reserved kind no effect", 20'h500, 16'h0005, 16'h0001, 24'h5001, 3'd1);
    doInv(2'b10, 16'h0005, 16'h0001);
    expectMiss("R8 vm+asid cleared", 20'h500, 16'h0005, 16'h0001);
    expectHit("R8 other asid kept", 20'h500, 16'h0005, 16'h0002, 24'h5002, 3'd2);
    expectHit("R8 other vm kept", 20'h500, 16'h0006, 16'h0001, 24'h6001, 3'd3);
    doFill(20'h501, 16'h0005, 16'h0009, 24'h5009, 3'd4);
    doInv(2'b01, 16'h0005, 16'h0000);
    expectMiss("R7 vm clears asid2", 20'h500, 16'h0005, 16'h0002);
    expectMiss("R7 vm clears asid9", 20'h501, 16'h0005, 16'h0009);
    expectHit("R7 other vm kept", 20'h500, 16'h0006, 16'h0001, 24'h6001, 3'd3);
  endtask

  task automatic testFillWithInv();
    doFill(20'h600, 16'h0008, 16'h0001, 24'h6600, 3'd1);
    @(negedge clk);
    invValid = 1'b1; invKind = 2'b01; invVmid = 16'h0008; invAsid = 16'h0;
    setFill(20'h601, 16'h0008, 16'h0001, 24'h6601, 3'd7);
    @(negedge clk);
    invValid = 1'b0; fillValid = 1'b0;
    expectMiss("R10 old entry invalidated", 20'h600, 16'h0008, 16'h0001);
    expectHit("R10 fill survives invalidate", 20'h601, 16'h0008, 16'h0001, 24'h6601, 3'd7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReplacement();
    testTags();
    testNarrow();
    testInvSelective();
    testFillWithInv();
    finishRun();
  end
endmodule